// File: doc/BRIEF.md
# Wake Event Status Register

This block collects four power-management wake events and holds each one in its own sticky flag until the host clears it. The four events are a wakeup-frame match, a magic-packet match, a link-up and an energy detect. The receive path and the PHY signal the first three with one-cycle pulses. Energy detect arrives on a level input that the block qualifies according to the selected mode. The host sees the flags as read-only bits of a status word.

The host never clears a flag by writing to the status word. It writes a 4-bit one-hot code into a separate clear field, and each code selects exactly one flag. Energy detect is accepted only while its enable bit is set. A mode bit chooses between two ways of accepting it:
- **Immediate:** the flag sets on the first cycle the energy input is high.
- **Delayed:** the flag sets only after the energy input has stayed high for a programmed number of consecutive cycles.

The block also drives a wake request. This output is the OR of every set flag whose individual enable bit is 1.

Top module: `pm_wake_status`

Register map. The host address selects one register, and `host_rdata` shows the selected register at all times.

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | Status | read-only | Bit 5 wakeup-frame flag, bit 4 magic-packet flag, bit 3 link-up flag, bit 2 energy flag. All other bits read 0. |
| 1 | Clear | write | Clear code in `wdata[5:2]`. Reads 0. |
| 2 | Enable | read/write | Bits 5..2 are the per-flag enables for the wake request, in the same bit order as the status word. Bit 2 also enables energy capture. Bit 0 selects delayed energy mode. Bit 1 and bits 15..6 read 0. |
| 3 | Delay | read/write | Delay count in bits [7:0]. |

## Requirements
- R1: After reset, all flags, the enable register and the delay register are 0. Reads of the status register (address 0) and the enable register (address 2) return 0x0000, and `wake_req_o` is 0.
- R2: Status bits 5, 4, 3 and 2 hold the wakeup-frame, magic-packet, link-up and energy flags respectively. Status bits 1:0 and 15:6 always read 0.
- R3: A one-cycle pulse on `evt_frame_i`, `evt_magic_i` or `evt_link_i` sets its flag at that clock edge. The flag then stays set through idle cycles until its clear code is written.
- R4: A write to address 1 with `wdata[5:2]` = 1000 clears the frame flag, 0100 clears the magic flag, 0010 clears the link flag and 0001 clears the energy flag. Each such write leaves the other flags unchanged.
- R5: A write to address 1 whose `wdata[5:2]` is not one-hot (for example 0000, 1100 or 1111) clears no flag.
- R6: When a set event and the clear code for the same flag occur in the same cycle, the flag ends up set.
- R7: With enable bit 2 = 1 and bit 0 = 0 (immediate mode), a single cycle of `energy_i` high sets the energy flag.
- R8: With enable bits 2 and 0 both 1 (delayed mode), the energy flag sets on the N-th consecutive cycle of `energy_i` high, where N is the delay register (address 3). A value of 0 acts as 1. A run shorter than N cycles sets nothing, and a low cycle restarts the count.
- R9: With enable bit 2 = 0, `energy_i` is ignored in both modes.
- R10: `wake_req_o` is 1 exactly when some flag is set and its enable bit (the enable register bit at that flag's status position) is 1.
- R11: Writes to the status register (address 0) change no flag, and writes to the clear register change no enable or delay setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Register select: 0 status, 1 clear, 2 enable, 3 delay |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the selected register (combinational) |
| evt_frame_i | input | 1 | Wakeup-frame match pulse |
| evt_magic_i | input | 1 | Magic-packet match pulse |
| evt_link_i | input | 1 | Link-up pulse |
| energy_i | input | 1 | Energy present on the line (level) |
| wake_req_o | output | 1 | Combined, masked wake request |

## Verification
A corrupted flag shows on the status read and, when its enable is set, on `wake_req_o` in the cycle after the edge that corrupted it. It stays visible until the matching clear code is written, because the flags are sticky. Faults in the clear decoder show as a flag that is lost after a non-one-hot code, or a neighbouring flag cleared along with the target. Both are visible on the next status read. Faults in the energy delay counter show as the flag appearing one cycle early or late, or appearing after a broken run. The bench therefore probes runs of N-1 and N cycles, as well as a run split by a low cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned NUM_FLAGS = 4;
    localparam int unsigned FLAG_LSB  = 2;
    localparam int unsigned FLAG_MSB  = FLAG_LSB + NUM_FLAGS - 1;

    // Flag indices; index i appears at status bit FLAG_LSB + i
    localparam int unsigned FLG_ENERGY = 0;
    localparam int unsigned FLG_LINK   = 1;
    localparam int unsigned FLG_MAGIC  = 2;
    localparam int unsigned FLG_FRAME  = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_DELAY  = 2'd3
    } reg_sel_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

endpackage

// File: rtl/wake_flag_bank.sv
module wake_flag_bank
    import wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    output flag_vec_t flags_o
);

    typedef struct packed {
        flag_vec_t flags;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (set_i[i]) begin
                st_d.flags[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flags[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag_chk
        // R6: a set in the same cycle as a clear leaves the flag set
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_o[g]);
        // R3: a set flag holds until a clear arrives
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
        // R3: a clear flag stays clear without a set event
        p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags_o[g] && !set_i[g]) |=> !flags_o[g]);
    end

endmodule

// File: rtl/wake_energy_qual.sv
module wake_energy_qual #(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             energy_i,
    input  logic             en_energy_i,
    input  logic             dly_mode_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             set_o
);

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        logic [DLY_W-1:0] run_cnt;
    } qual_state_t;

    qual_state_t      st_d, st_q;
    logic [DLY_W-1:0] n_eff;
    logic             armed;

    assign n_eff = (dly_i == '0) ? ONE : dly_i;
    assign armed = en_energy_i && energy_i;

    always_comb begin
        st_d = st_q;
        if (!armed || !dly_mode_i) begin
            st_d.run_cnt = '0;
        end else if (st_q.run_cnt < n_eff) begin
            st_d.run_cnt = st_q.run_cnt + ONE;
        end
    end

    always_comb begin
        if (!armed) begin
            set_o = 1'b0;
        end else if (dly_mode_i) begin
            set_o = (st_q.run_cnt == n_eff - ONE);
        end else begin
            set_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: in delayed mode with N above 1, a qualified set needs the input high the cycle before
    p_delay_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o && dly_mode_i && $stable(dly_i) && (n_eff > ONE)) |-> $past(energy_i));

    // R9: no energy set while energy capture is disabled
    p_energy_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_energy_i |-> !set_o);

endmodule

// File: rtl/wake_host_regs.sv
module wake_host_regs
    import wake_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  flag_vec_t         flags_i,
    output logic [DATA_W-1:0] rdata_o,
    output flag_vec_t         clr_o,
    output flag_vec_t         en_mask_o,
    output logic              dly_mode_o,
    output logic [DLY_W-1:0]  dly_o
);

    typedef struct packed {
        flag_vec_t        en_mask;
        logic             dly_mode;
        logic [DLY_W-1:0] dly;
    } regs_state_t;

    regs_state_t st_d, st_q;
    flag_vec_t   code;
    logic        code_onehot;
    reg_sel_e    sel;
    logic        unused_wdata;

    assign sel          = reg_sel_e'(addr_i);
    assign code         = wdata_i[FLAG_MSB:FLAG_LSB];
    assign code_onehot  = (code != '0) && ((code & (code - 1'b1)) == '0);
    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (we_i) begin
            unique case (sel)
                REG_CLEAR: begin
                    if (code_onehot) begin
                        clr_o = code;
                    end
                end
                REG_ENABLE: begin
                    st_d.en_mask  = wdata_i[FLAG_MSB:FLAG_LSB];
                    st_d.dly_mode = wdata_i[0];
                end
                REG_DELAY: begin
                    st_d.dly = wdata_i[DLY_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_STATUS: rdata_o[FLAG_MSB:FLAG_LSB] = flags_i;
            REG_ENABLE: begin
                rdata_o[FLAG_MSB:FLAG_LSB] = st_q.en_mask;
                rdata_o[0]                 = st_q.dly_mode;
            end
            REG_DELAY:  rdata_o[DLY_W-1:0] = st_q.dly;
            default:    rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_mask_o  = st_q.en_mask;
    assign dly_mode_o = st_q.dly_mode;
    assign dly_o      = st_q.dly;

    // R5: the decoder never clears more than one flag per write
    p_clear_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    // R11: status and clear writes leave the settings unchanged
    p_settings_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (sel == REG_STATUS || sel == REG_CLEAR))
            |=> ($stable(en_mask_o) && $stable(dly_mode_o) && $stable(dly_o)));

endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status
    import wake_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              evt_frame_i,
    input  logic              evt_magic_i,
    input  logic              evt_link_i,
    input  logic              energy_i,
    output logic              wake_req_o
);

    flag_vec_t        flags;
    flag_vec_t        set_vec;
    flag_vec_t        clr_vec;
    flag_vec_t        en_mask;
    logic             dly_mode;
    logic [DLY_W-1:0] dly;
    logic             energy_set;

    wake_host_regs #(.DLY_W(DLY_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (host_we),
        .addr_i     (host_addr),
        .wdata_i    (host_wdata),
        .flags_i    (flags),
        .rdata_o    (host_rdata),
        .clr_o      (clr_vec),
        .en_mask_o  (en_mask),
        .dly_mode_o (dly_mode),
        .dly_o      (dly)
    );

    wake_energy_qual #(.DLY_W(DLY_W)) u_energy (
        .clk         (clk),
        .rst_n       (rst_n),
        .energy_i    (energy_i),
        .en_energy_i (en_mask[FLG_ENERGY]),
        .dly_mode_i  (dly_mode),
        .dly_i       (dly),
        .set_o       (energy_set)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[FLG_FRAME]  = evt_frame_i;
        set_vec[FLG_MAGIC]  = evt_magic_i;
        set_vec[FLG_LINK]   = evt_link_i;
        set_vec[FLG_ENERGY] = energy_set;
    end

    wake_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    assign wake_req_o = |(flags & en_mask);

    // R10: a wake request needs at least one flag readable in the status word
    p_wake_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (flags != '0));

    // R2: reserved status bits read as zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == REG_STATUS) |-> (host_rdata[1:0] == 2'b00 && host_rdata[DATA_W-1:FLAG_MSB+1] == '0));

endmodule

// File: tb/pm_wake_status_bench.sv
module pm_wake_status_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        evt_frame_i = 1'b0;
    logic        evt_magic_i = 1'b0;
    logic        evt_link_i = 1'b0;
    logic        energy_i = 1'b0;
    logic        wake_req_o;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];
    event        sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_wake_status u_pm_wake_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .evt_frame_i(evt_frame_i),
        .evt_magic_i(evt_magic_i),
        .evt_link_i (evt_link_i),
        .energy_i   (energy_i),
        .wake_req_o (wake_req_o)
    );

    // Monitor: pops the expected item and compares it shortly after the driver sets the address
    initial begin
        forever begin
            @(sample_ev);
            #1;
            if (exp_q.size() != 0) begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (host_rdata !== e[15:0] || wake_req_o !== e[16]) begin
                    failures++;
                    $display("FAIL %s rdata=%h exp=%h wake=%b exp=%b",
                             t, host_rdata, e[15:0], wake_req_o, e[16]);
                end
            end
        end
    end

    task automatic rd_check(input logic [1:0] a, input logic [15:0] exp, input logic wk, input string t);
        @(negedge clk);
        host_addr = a;
        exp_q.push_back({wk, exp});
        tag_q.push_back(t);
        -> sample_ev;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse(input logic f, input logic m, input logic l, input logic en);
        @(negedge clk);
        evt_frame_i = f;
        evt_magic_i = m;
        evt_link_i = l;
        energy_i = en;
        @(negedge clk);
        evt_frame_i = 1'b0;
        evt_magic_i = 1'b0;
        evt_link_i = 1'b0;
        energy_i = 1'b0;
    endtask

    task automatic hold_energy(input int n);
        @(negedge clk);
        energy_i = 1'b1;
        repeat (n) @(negedge clk);
        energy_i = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check(2'd0, 16'h0000, 1'b0, "R1 status after reset");
        rd_check(2'd2, 16'h0000, 1'b0, "R1 enable after reset");
        rd_check(2'd3, 16'h0000, 1'b0, "R1 delay after reset");

        // All wake enables on, immediate energy mode
        wr(2'd2, 16'h003C);
        rd_check(2'd2, 16'h003C, 1'b0, "R2 enable readback bit1 reserved");

        // R3 frame event sets bit 5
        pulse(1, 0, 0, 0);
        rd_check(2'd0, 16'h0020, 1'b1, "R3 frame flag set");
        repeat (5) @(negedge clk);
        rd_check(2'd0, 16'h0020, 1'b1, "R3 frame flag sticky");

        pulse(0, 1, 1, 0);
        rd_check(2'd0, 16'h0038, 1'b1, "R2 magic bit4 link bit3");

        // R4 clear magic (code 0100)
        wr(2'd1, 16'h0010);
        rd_check(2'd0, 16'h0028, 1'b1, "R4 clear magic only");

        // R5 non-one-hot codes
        wr(2'd1, 16'h0030);
        rd_check(2'd0, 16'h0028, 1'b1, "R5 code 1100 clears nothing");
        wr(2'd1, 16'h0000);
        rd_check(2'd0, 16'h0028, 1'b1, "R5 code 0000 clears nothing");
        wr(2'd1, 16'h003C);
        rd_check(2'd0, 16'h0028, 1'b1, "R5 code 1111 clears nothing");

        // R4 clear frame then link
        wr(2'd1, 16'h0020);
        rd_check(2'd0, 16'h0008, 1'b1, "R4 clear frame only");
        wr(2'd1, 16'h0008);
        rd_check(2'd0, 16'h0000, 1'b0, "R4 clear link");

        // R7 immediate energy
        pulse(0, 0, 0, 1);
        rd_check(2'd0, 16'h0004, 1'b1, "R7 immediate energy one cycle");
        wr(2'd1, 16'h0004);
        rd_check(2'd0, 16'h0000, 1'b0, "R4 clear energy");

        // R6 set and clear same cycle
        @(negedge clk);
        evt_link_i = 1'b1;
        host_we = 1'b1;
        host_addr = 2'd1;
        host_wdata = 16'h0008;
        @(negedge clk);
        evt_link_i = 1'b0;
        host_we = 1'b0;
        rd_check(2'd0, 16'h0008, 1'b1, "R6 set wins over clear");
        wr(2'd1, 16'h0008);

        // R11 status write has no effect; clear write keeps settings
        pulse(0, 1, 0, 0);
        wr(2'd0, 16'hFFFF);
        rd_check(2'd0, 16'h0010, 1'b1, "R11 status write ignored");
        wr(2'd1, 16'h0010);
        rd_check(2'd2, 16'h003C, 1'b0, "R11 clear write keeps enable");

        // R9 energy disabled
        wr(2'd2, 16'h0038);
        pulse(0, 0, 0, 1);
        hold_energy(5);
        rd_check(2'd0, 16'h0000, 1'b0, "R9 energy ignored when disabled");
        wr(2'd2, 16'h0039);
        hold_energy(5);
        rd_check(2'd0, 16'h0000, 1'b0, "R9 energy ignored delayed mode disabled");

        // R10 masking
        wr(2'd2, 16'h0008);
        pulse(0, 1, 0, 0);
        rd_check(2'd0, 16'h0010, 1'b0, "R10 masked flag no wake");
        wr(2'd2, 16'h0018);
        rd_check(2'd0, 16'h0010, 1'b1, "R10 enabled flag wakes");
        wr(2'd1, 16'h0010);
        rd_check(2'd0, 16'h0000, 1'b0, "R10 wake drops after clear");

        // R8 delayed energy, N=3
        wr(2'd2, 16'h0005);
        wr(2'd3, 16'h0003);
        rd_check(2'd3, 16'h0003, 1'b0, "R8 delay readback");
        hold_energy(2);
        rd_check(2'd0, 16'h0000, 1'b0, "R8 run of N-1 sets nothing");
        hold_energy(2);
        pulse(0, 0, 0, 1);
        rd_check(2'd0, 16'h0000, 1'b0, "R8 broken run sets nothing");
        hold_energy(3);
        rd_check(2'd0, 16'h0004, 1'b1, "R8 run of N sets flag");
        wr(2'd1, 16'h0004);
        rd_check(2'd0, 16'h0000, 1'b0, "R8 energy cleared");

        // R8 delay 0 acts as 1
        wr(2'd3, 16'h0000);
        pulse(0, 0, 0, 1);
        rd_check(2'd0, 16'h0004, 1'b1, "R8 delay zero acts as one");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule